// File: doc/BRIEF.md
# Bang-Bang Phase Error Proportional and Decimated Integral Path

This block sits after a half-rate bang-bang phase detector in a digital clock recovery loop. On each cycle marked valid it takes two early/late decision pairs, one for the odd bit and one for the even bit. Each pair becomes a ternary value. The two values add into a five-level proportional code that steers the oscillator with a single register of latency.

The same decisions also feed the slow integral branch. Each cycle's pair of ternary values is truncated to one ternary error sample. The stream then passes through a chain of decimate-by-2 stages. Each stage adds two consecutive samples and truncates the sum back to {-1, 0, +1}. The surviving sample, scaled by a power-of-two gain, goes into a saturating signed accumulator that forms the integral control word.

A mode input removes the even pair from both branches. With it set, only the odd decisions steer the loop, which is how the loop runs while a separate calibration watches the even pair.

Top module: `phase_err_path`

## Requirements
- R1: Each early/late pair maps to a ternary value: early alone gives +1, late alone gives -1, and neither or both gives 0.
- R2: On the clock edge that captures a valid cycle, `prop_code` (3-bit two's complement, range -2..+2) becomes the sum of the odd and even ternary values.
- R3: While `odd_only` is 1, the even pair contributes 0 to both the proportional code and the integral error sample.
- R4: The per-cycle error sample fed to decimation is the truncated sum of the two ternary values: positive gives +1, negative gives -1, and zero gives 0.
- R5: Each of the four stages pairs consecutive valid inputs and emits the truncated sum of each pair. Counting valid cycles from reset, each aligned group of 16 therefore produces exactly one integral update.
- R6: Let the edge that captures the 16th valid cycle of a group be edge 1. The update appears at the output on edge 5, and `int_valid` is high for exactly that one cycle.
- R7: The integral update adds the decimated ternary sample multiplied by 2^GAIN_SHIFT (64 by default) to `int_word`.
- R8: `int_word` saturates at the 14-bit signed limits +8191 and -8192 and never wraps.
- R9: After reset, `prop_code` and `int_word` are 0, `int_valid` is 0, and no partial decimation pair is held.
- R10: Cycles with `pd_valid` low change neither `prop_code` nor `int_word` and do not advance decimation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_valid | input | 1 | Decision pairs valid this cycle |
| odd_early | input | 1 | Odd-bit early decision |
| odd_late | input | 1 | Odd-bit late decision |
| even_early | input | 1 | Even-bit early decision |
| even_late | input | 1 | Even-bit late decision |
| odd_only | input | 1 | Ignore the even pair |
| prop_code | output | 3 | Signed proportional code, -2..+2 |
| int_word | output | 14 | Signed saturating integral control word |
| int_valid | output | 1 | One-cycle pulse when `int_word` updates |

## Verification
A wrong value held in a decimation stage or a misaligned pairing does not show up at once. It shows at the next integral update: the `int_valid` pulse lands on the wrong cycle, or `int_word` steps by the wrong amount, within at most 16 valid cycles plus four edges. Proportional errors show on the very next edge, because `prop_code` is one register from the inputs. Saturation faults only appear after long one-sided runs, so the stimulus drives the word into both limits and holds it there.

// File: rtl/phdet_pkg.sv
package phdet_pkg;

    typedef logic signed [1:0] tern_t;

    function automatic tern_t tern_of_pair(input logic early, input logic late);
        tern_t r;
        if (early && !late)      r = 2'sd1;
        else if (late && !early) r = -2'sd1;
        else                     r = 2'sd0;
        return r;
    endfunction

    function automatic tern_t tern_sum(input tern_t a, input tern_t b);
        logic signed [2:0] s;
        tern_t r;
        s = {a[1], a} + {b[1], b};
        if (s > 3'sd0)      r = 2'sd1;
        else if (s < 3'sd0) r = -2'sd1;
        else                r = 2'sd0;
        return r;
    endfunction

endpackage

// File: rtl/tern_decim_stage.sv
module tern_decim_stage
    import phdet_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_v,
    input  tern_t in_x,
    output logic  out_v,
    output tern_t out_x
);

    typedef struct packed {
        logic  have;
        tern_t held;
        logic  ov;
        tern_t ox;
    } stage_st_t;

    stage_st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.ov = 1'b0;
        if (in_v) begin
            if (!s_q.have) begin
                s_d.have = 1'b1;
                s_d.held = in_x;
            end else begin
                s_d.have = 1'b0;
                s_d.ox   = tern_sum(s_q.held, in_x);
                s_d.ov   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_v = s_q.ov;
    assign out_x = s_q.ox;

    AST_STAGE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ov |=> !s_q.ov); // R5
    AST_STAGE_TERN: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ov |-> (s_q.ox != 2'b10)); // R5

endmodule

// File: rtl/sat_int_accum.sv
module sat_int_accum
    import phdet_pkg::*;
#(
    parameter int W          = 14,
    parameter int GAIN_SHIFT = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_v,
    input  tern_t        in_x,
    output logic [W-1:0] acc,
    output logic         upd
);

    localparam logic signed [W:0]   HI_EXT = $signed({2'b00, {(W-1){1'b1}}});
    localparam logic signed [W:0]   LO_EXT = $signed({2'b11, {(W-1){1'b0}}});
    localparam logic signed [W-1:0] HI     = $signed({1'b0, {(W-1){1'b1}}});
    localparam logic signed [W-1:0] LO     = $signed({1'b1, {(W-1){1'b0}}});

    typedef struct packed {
        logic signed [W-1:0] acc;
        logic                upd;
    } acc_st_t;

    acc_st_t a_d, a_q;
    logic signed [W:0] step, sum;

    always_comb begin
        step    = $signed({{(W-1){in_x[1]}}, in_x}) <<< GAIN_SHIFT;
        sum     = $signed({a_q.acc[W-1], a_q.acc}) + step;
        a_d     = a_q;
        a_d.upd = 1'b0;
        if (in_v) begin
            a_d.upd = 1'b1;
            if (sum > HI_EXT)      a_d.acc = HI;
            else if (sum < LO_EXT) a_d.acc = LO;
            else                   a_d.acc = sum[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign acc = a_q.acc;
    assign upd = a_q.upd;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_v && in_x == 2'sd1 && a_q.acc == HI) |=> (a_q.acc == HI)); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_v && in_x == -2'sd1 && a_q.acc == LO) |=> (a_q.acc == LO)); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_v |=> $stable(a_q.acc)); // R10

endmodule

// File: rtl/phase_err_path.sv
module phase_err_path
    import phdet_pkg::*;
#(
    parameter int N_STAGES   = 4,
    parameter int INT_W      = 14,
    parameter int GAIN_SHIFT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_valid,
    input  logic             odd_early,
    input  logic             odd_late,
    input  logic             even_early,
    input  logic             even_late,
    input  logic             odd_only,
    output logic [2:0]       prop_code,
    output logic [INT_W-1:0] int_word,
    output logic             int_valid
);

    localparam int DECIM = 1 << N_STAGES;

    typedef struct packed {
        logic signed [2:0] prop;
    } prop_st_t;

    prop_st_t p_d, p_q;
    tern_t    t_odd, t_even, err_smp;

    logic  [N_STAGES:0] v_ch;
    tern_t [N_STAGES:0] x_ch;

    always_comb begin
        t_odd   = tern_of_pair(odd_early, odd_late);
        t_even  = odd_only ? 2'sd0 : tern_of_pair(even_early, even_late);
        err_smp = tern_sum(t_odd, t_even);
        p_d     = p_q;
        if (pd_valid) p_d.prop = {t_odd[1], t_odd} + {t_even[1], t_even};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign prop_code = p_q.prop;
    assign v_ch[0]   = pd_valid;
    assign x_ch[0]   = err_smp;

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        tern_decim_stage u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .in_v  (v_ch[g]),
            .in_x  (x_ch[g]),
            .out_v (v_ch[g+1]),
            .out_x (x_ch[g+1])
        );
    end

    sat_int_accum #(.W(INT_W), .GAIN_SHIFT(GAIN_SHIFT)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .in_v  (v_ch[N_STAGES]),
        .in_x  (x_ch[N_STAGES]),
        .acc   (int_word),
        .upd   (int_valid)
    );

    initial begin
        AST_DECIM_PARAM: assert (DECIM >= 2); // R5
    end

    AST_PROP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(prop_code) <= 3'sd2) && ($signed(prop_code) >= -3'sd2)); // R2
    AST_PROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_valid |=> $stable(prop_code)); // R10
    AST_ODD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_valid && odd_only && (odd_early == odd_late)) |=> (prop_code == 3'd0)); // R3

endmodule

// File: tb/sim_phase_err_path.sv
module sim_phase_err_path;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_valid = 1'b0, odd_early = 1'b0, odd_late = 1'b0;
    logic even_early = 1'b0, even_late = 1'b0, odd_only = 1'b0;
    logic [2:0]  prop_code;
    logic [13:0] int_word;
    logic        int_valid;

    always #2.5 clk = ~clk;

    phase_err_path u0 (
        .clk(clk), .rst_n(rst_n), .pd_valid(pd_valid),
        .odd_early(odd_early), .odd_late(odd_late),
        .even_early(even_early), .even_late(even_late),
        .odd_only(odd_only), .prop_code(prop_code),
        .int_word(int_word), .int_valid(int_valid)
    );

    int n_tests = 0, n_fail = 0, cyc = 0;
    bit done = 0, cmp_en = 0;

    // behavioural reference model
    int exp_prop = 0, exp_int = 0, exp_iv = 0;
    int smp_q[$];
    int pend_val = 0, countdown = 0;

    function automatic int tval(input logic e, input logic l);
        if (e && !l) return 1;
        if (l && !e) return -1;
        return 0;
    endfunction

    function automatic int sgn(input int v);
        return (v > 0) ? 1 : ((v < 0) ? -1 : 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_prop = 0; exp_int = 0; exp_iv = 0;
            smp_q.delete(); countdown = 0;
        end else begin
            exp_iv = 0;
            if (countdown > 0) begin
                countdown--;
                if (countdown == 0) begin
                    exp_int = exp_int + pend_val * 64;
                    if (exp_int > 8191)  exp_int = 8191;
                    if (exp_int < -8192) exp_int = -8192;
                    exp_iv = 1;
                end
            end
            if (pd_valid) begin
                int to, te;
                to = tval(odd_early, odd_late);
                te = odd_only ? 0 : tval(even_early, even_late);
                exp_prop = to + te;
                smp_q.push_back(sgn(to + te));
                if (smp_q.size() == 16) begin
                    int arr[16];
                    for (int i = 0; i < 16; i++) arr[i] = smp_q[i];
                    for (int len = 16; len > 1; len = len / 2)
                        for (int i = 0; i < len / 2; i++)
                            arr[i] = sgn(arr[2*i] + arr[2*i+1]);
                    pend_val = arr[0];
                    countdown = 4;
                    smp_q.delete();
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            check($signed(prop_code) == exp_prop, "R2 prop_code", $signed(prop_code), exp_prop);
            check($signed(int_word) == exp_int, "R7 int_word", $signed(int_word), exp_int);
            check(int_valid == exp_iv[0], "R6 int_valid", int_valid, exp_iv);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic drive(input logic v, input logic oe, input logic ol,
                         input logic ee, input logic el, input logic mo);
        pd_valid = v; odd_early = oe; odd_late = ol;
        even_early = ee; even_late = el; odd_only = mo;
        @(negedge clk);
    endtask

    initial begin
        int pulses;
        @(negedge clk); @(negedge clk);
        // R9: reset state
        check(prop_code == 3'd0, "R9 prop after reset", $signed(prop_code), 0);
        check(int_word == 14'd0, "R9 int after reset", $signed(int_word), 0);
        check(int_valid == 1'b0, "R9 valid after reset", int_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1;

        // R4: odd early + even late cancel -> zero samples
        pulses = 0;
        for (int i = 0; i < 16; i++) drive(1, 1, 0, 0, 1, 0);
        for (int i = 0; i < 6; i++) begin
            if (int_valid) pulses++;
            drive(0, 0, 0, 0, 0, 0);
        end
        check($signed(int_word) == 0, "R4 cancelling pairs", $signed(int_word), 0);
        check(pulses == 1, "R5 one update per 16", pulses, 1);

        // R6/R7: 16 odd-early cycles -> +64 on edge 5
        for (int i = 0; i < 16; i++) drive(1, 1, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        check(int_valid == 1'b0 && $signed(int_word) == 0, "R6 not before edge 5", $signed(int_word), 0);
        drive(0, 0, 0, 0, 0, 0);
        check(int_valid == 1'b1, "R6 pulse on edge 5", int_valid, 1);
        check($signed(int_word) == 64, "R7 gain step", $signed(int_word), 64);

        // R1: odd early only -> +1 ; R2 both early -> +2, both late -> -2
        drive(1, 1, 0, 0, 0, 0);
        check($signed(prop_code) == 1, "R1 early alone", $signed(prop_code), 1);
        drive(1, 1, 1, 0, 0, 0);
        check($signed(prop_code) == 0, "R1 both asserted", $signed(prop_code), 0);
        drive(1, 1, 0, 1, 0, 0);
        check($signed(prop_code) == 2, "R2 plus two", $signed(prop_code), 2);
        drive(1, 0, 1, 0, 1, 0);
        check($signed(prop_code) == -2, "R2 minus two", $signed(prop_code), -2);
        // R10: idle cycle holds
        drive(0, 1, 0, 1, 0, 0);
        check($signed(prop_code) == -2, "R10 idle holds", $signed(prop_code), -2);
        // R3: even ignored in odd-only mode
        drive(1, 0, 0, 1, 0, 1);
        check($signed(prop_code) == 0, "R3 even ignored", $signed(prop_code), 0);
        drive(1, 0, 1, 1, 0, 1);
        check($signed(prop_code) == -1, "R3 odd only drives", $signed(prop_code), -1);

        // all ternary combinations in both modes
        for (int m = 0; m < 2; m++)
            for (int c = 0; c < 16; c++)
                drive(1, c[0], c[1], c[2], c[3], m[0]);

        // random traffic with gaps
        for (int i = 0; i < 4000; i++)
            drive($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 1),
                  $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 7) == 0);

        // R8: drive to the upper limit and hold
        for (int i = 0; i < 16 * 270; i++) drive(1, 1, 0, 1, 0, 0);
        for (int i = 0; i < 6; i++) drive(0, 0, 0, 0, 0, 0);
        check($signed(int_word) == 8191, "R8 upper limit", $signed(int_word), 8191);
        // R8: drive to the lower limit and hold
        for (int i = 0; i < 16 * 270; i++) drive(1, 0, 1, 0, 1, 0);
        for (int i = 0; i < 6; i++) drive(0, 0, 0, 0, 0, 0);
        check($signed(int_word) == -8192, "R8 lower limit", $signed(int_word), -8192);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule